// File: doc/BRIEF.md
# Floppy Data Rate and Power Control

This block holds the write-only rate/precompensation register of a floppy controller, together with the rate field of its companion configuration register. The host writes a byte to the rate register to choose the data rate, the write precompensation delay code and a manual low-power request. Setting the top bit of that byte also requests a software reset. The configuration register carries only a 2-bit rate field. Whichever register was written last decides the rate that the rest of the controller uses.

Low power is driven out as a clock-gate request that stops the controller clock and the data separator. The request drops on a software reset, whether it comes from outside the block or from the block's own self-clearing reset bit. It also drops when the host touches the data register or the main status register. Because the rate register cannot be read back, every byte written to it is kept verbatim in a shadow value that firmware can read through another path.

Top module: `fdc_rate_power_ctl`

## Requirements
- R1: After hardware reset, rateCode is 2'b10 (250 Kbps), precompCode is 0, clkGateReq is 0, swRstPulse is 0 and shadowVal is 8'h02.
- R2: A write to the rate register (rateWrEn) loads rateCode from rateWrData[1:0] and precompCode from rateWrData[4:2]. Both outputs show the new value on the clock edge that takes the write.
- R3: A write to the configuration register (cfgWrEn) loads rateCode from cfgWrData[1:0] and leaves precompCode and shadowVal unchanged.
- R4: When both registers are written in the same cycle, rateCode takes cfgWrData[1:0]. precompCode and shadowVal still take the rate-register byte.
- R5: A rate-register write with rateWrData[7]=1 produces swRstPulse high for exactly the one cycle after the write. The bit is not held, and the reset leaves rateCode and precompCode unchanged.
- R6: A rate-register write with rateWrData[6]=1 raises clkGateReq after that edge, and clkGateReq stays high until an exit event.
- R7: Each of fifoAccess, statusAccess, swRstReq and swRstPulse clears clkGateReq at the next edge. An exit event in the same cycle as a low-power write wins over it.
- R8: shadowVal holds the last byte written to the rate register, including bits 7 and 6, and ignores configuration writes.
- R9: swRstReq and the access strobes change none of rateCode, precompCode or shadowVal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| rateWrEn | input | 1 | Write strobe for the rate/precompensation register |
| rateWrData | input | 8 | Byte written to the rate register |
| cfgWrEn | input | 1 | Write strobe for the configuration register |
| cfgWrData | input | 2 | Rate field written to the configuration register |
| fifoAccess | input | 1 | Host access to the data register |
| statusAccess | input | 1 | Host access to the main status register |
| swRstReq | input | 1 | Software reset from elsewhere in the controller |
| rateCode | output | 2 | Effective data rate code |
| precompCode | output | 3 | Write precompensation select |
| clkGateReq | output | 1 | Low-power request, gates clock and data separator |
| swRstPulse | output | 1 | One-cycle software reset from the self-clearing bit |
| shadowVal | output | 8 | Readable copy of the last rate-register byte |

## Verification
The bench alternates writes to the two registers and then writes both in one cycle. A design without last-writer-wins ordering, or with the wrong priority, would show a stale rate there. It enters low power and leaves it through each trigger in turn, and it also writes a byte that sets the low-power and reset bits together. A design that held the reset bit, or that let the set beat the exit, would leave the clock gated. It checks that the shadow keeps bits 7 and 6 and ignores configuration writes, which catches a shadow that tracks the effective rate instead of the written byte.

// File: rtl/frp_pkg.sv
package frp_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned RATE_W    = 2;
  localparam int unsigned PRECOMP_W = 3;
  localparam int unsigned PRECOMP_LSB = RATE_W;
  localparam int unsigned PRECOMP_MSB = PRECOMP_LSB + PRECOMP_W - 1;
  localparam int unsigned LOWPWR_BIT  = REG_W - 2;
  localparam int unsigned SWRST_BIT   = REG_W - 1;
  localparam logic [REG_W-1:0] RST_BYTE = 8'h02;

  typedef struct packed {
    logic loadRate;   // rate register write
    logic loadCfg;    // configuration register write
    logic setLowPwr;  // low power request written
    logic clrLowPwr;  // any low power exit event
  } ctlStrobes_t;
endpackage

// File: rtl/frp_control.sv
module frp_control
  import frp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rateWrEn,
  input  logic [REG_W-1:0] rateWrData,
  input  logic             cfgWrEn,
  input  logic             fifoAccess,
  input  logic             statusAccess,
  input  logic             swRstReq,
  output ctlStrobes_t      strobes,
  output logic             resetPulse
);
  logic resetPulseQ;

  // self-clearing reset bit: a one-cycle pulse after each write that sets it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resetPulseQ <= 1'b0;
    else       resetPulseQ <= rateWrEn & rateWrData[SWRST_BIT];
  end

  always_comb begin
    strobes.loadRate  = rateWrEn;
    strobes.loadCfg   = cfgWrEn;
    strobes.setLowPwr = rateWrEn & rateWrData[LOWPWR_BIT];
    strobes.clrLowPwr = fifoAccess | statusAccess | swRstReq | resetPulseQ;
  end

  assign resetPulse = resetPulseQ;

  // R5: the pulse only follows a write with the reset bit set
  a_r5_pulse_source: assert property (@(posedge clk) disable iff (!rstN)
    resetPulseQ |-> $past(rateWrEn && rateWrData[SWRST_BIT]));

  // R5: no pulse without a preceding reset-bit write
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rateWrEn && rateWrData[SWRST_BIT]) |-> !resetPulseQ);
endmodule

// File: rtl/frp_datapath.sv
module frp_datapath
  import frp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strobes,
  input  logic [REG_W-1:0]     rateWrData,
  input  logic [RATE_W-1:0]    cfgWrData,
  output logic [RATE_W-1:0]    rateCode,
  output logic [PRECOMP_W-1:0] precompCode,
  output logic                 lowPower,
  output logic [REG_W-1:0]     shadowVal
);
  logic [RATE_W-1:0]    rateQ;
  logic [PRECOMP_W-1:0] precompQ;
  logic                 lowPowerQ;
  logic [REG_W-1:0]     shadowQ;

  // effective rate: most recent writer wins, configuration wins a tie
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rateQ <= RST_BYTE[RATE_W-1:0];
    else if (strobes.loadCfg)  rateQ <= cfgWrData;
    else if (strobes.loadRate) rateQ <= rateWrData[RATE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 precompQ <= RST_BYTE[PRECOMP_MSB:PRECOMP_LSB];
    else if (strobes.loadRate) precompQ <= rateWrData[PRECOMP_MSB:PRECOMP_LSB];
  end

  // exit events beat a same-cycle low power request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  lowPowerQ <= 1'b0;
    else if (strobes.clrLowPwr) lowPowerQ <= 1'b0;
    else if (strobes.setLowPwr) lowPowerQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 shadowQ <= RST_BYTE;
    else if (strobes.loadRate) shadowQ <= rateWrData;
  end

  assign rateCode    = rateQ;
  assign precompCode = precompQ;
  assign lowPower    = lowPowerQ;
  assign shadowVal   = shadowQ;

  // R4: a configuration write always sets the rate
  a_r4_cfg_wins: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.loadCfg) |-> rateQ == $past(cfgWrData));

  // R7: an exit event always leaves low power
  a_r7_exit_clears: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.clrLowPwr) |-> !lowPowerQ);

  // R8: the shadow copies the written byte
  a_r8_shadow_copy: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.loadRate) |-> shadowQ == $past(rateWrData));

  // R9: precompensation only moves on a rate register write
  a_r9_precomp_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.loadRate) |-> $stable(precompQ));

  // R6: low power only rises on a write that requests it
  a_r6_set_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lowPowerQ) |-> $past(strobes.setLowPwr));
endmodule

// File: rtl/fdc_rate_power_ctl.sv
module fdc_rate_power_ctl
  import frp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rateWrEn,
  input  logic [7:0] rateWrData,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgWrData,
  input  logic       fifoAccess,
  input  logic       statusAccess,
  input  logic       swRstReq,
  output logic [1:0] rateCode,
  output logic [2:0] precompCode,
  output logic       clkGateReq,
  output logic       swRstPulse,
  output logic [7:0] shadowVal
);
  ctlStrobes_t strobes;

  frp_control i_control (
    .clk(clk), .rstN(rstN),
    .rateWrEn(rateWrEn), .rateWrData(rateWrData), .cfgWrEn(cfgWrEn),
    .fifoAccess(fifoAccess), .statusAccess(statusAccess), .swRstReq(swRstReq),
    .strobes(strobes), .resetPulse(swRstPulse)
  );

  frp_datapath i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .rateWrData(rateWrData), .cfgWrData(cfgWrData),
    .rateCode(rateCode), .precompCode(precompCode),
    .lowPower(clkGateReq), .shadowVal(shadowVal)
  );
endmodule

// File: tb/test_fdc_rate_power_ctl.sv
module test_fdc_rate_power_ctl;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rateWrEn = 1'b0, cfgWrEn = 1'b0;
  logic [7:0] rateWrData = '0;
  logic [1:0] cfgWrData = '0;
  logic fifoAccess = 1'b0, statusAccess = 1'b0, swRstReq = 1'b0;
  logic [1:0] rateCode;
  logic [2:0] precompCode;
  logic clkGateReq, swRstPulse;
  logic [7:0] shadowVal;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdc_rate_power_ctl i_fdc_rate_power_ctl (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearIn();
    rateWrEn = 0; cfgWrEn = 0; fifoAccess = 0; statusAccess = 0; swRstReq = 0;
  endtask

  // drive at negedge, outputs sampled at the following negedge
  task automatic writeRate(input logic [7:0] d);
    @(negedge clk); rateWrEn = 1; rateWrData = d;
    @(negedge clk); clearIn();
  endtask

  task automatic writeCfg(input logic [1:0] d);
    @(negedge clk); cfgWrEn = 1; cfgWrData = d;
    @(negedge clk); clearIn();
  endtask

  task automatic testReset();
    chk("R1 rate", rateCode, 2);
    chk("R1 precomp", precompCode, 0);
    chk("R1 clkgate", clkGateReq, 0);
    chk("R1 pulse", swRstPulse, 0);
    chk("R1 shadow", shadowVal, 8'h02);
  endtask

  task automatic testRateWrite();
    writeRate(8'b000_101_11);
    chk("R2 rate", rateCode, 3);
    chk("R2 precomp", precompCode, 5);
    writeRate(8'b000_010_00);
    chk("R2 rate second", rateCode, 0);
    chk("R2 precomp second", precompCode, 2);
  endtask

  task automatic testLastWriter();
    writeCfg(2'b01);
    chk("R3 rate from cfg", rateCode, 1);
    chk("R3 precomp kept", precompCode, 2);
    chk("R3 shadow kept", shadowVal, 8'h08);
    writeRate(8'b000_011_10);
    chk("R2 rate after cfg", rateCode, 2);
    @(negedge clk); rateWrEn = 1; rateWrData = 8'b000_110_00; cfgWrEn = 1; cfgWrData = 2'b11;
    @(negedge clk); clearIn();
    chk("R4 cfg wins tie", rateCode, 3);
    chk("R4 precomp from rate", precompCode, 6);
    chk("R4 shadow from rate", shadowVal, 8'h18);
  endtask

  task automatic enterLowPower();
    writeRate({2'b01, 1'b0, 3'b001, 2'b01});
    chk("R6 clkgate set", clkGateReq, 1);
    repeat (3) @(negedge clk);
    chk("R6 clkgate held", clkGateReq, 1);
  endtask

  task automatic testExits();
    enterLowPower();
    @(negedge clk); fifoAccess = 1;
    @(negedge clk); clearIn();
    chk("R7 exit fifo", clkGateReq, 0);
    chk("R9 fifo keeps rate", rateCode, 1);
    enterLowPower();
    @(negedge clk); statusAccess = 1;
    @(negedge clk); clearIn();
    chk("R7 exit status", clkGateReq, 0);
    enterLowPower();
    @(negedge clk); swRstReq = 1;
    @(negedge clk); clearIn();
    chk("R7 exit swRstReq", clkGateReq, 0);
    chk("R9 swRstReq keeps precomp", precompCode, 1);
    chk("R9 swRstReq keeps shadow", shadowVal, 8'h45);
    // exit beats a same-cycle low power write
    @(negedge clk); rateWrEn = 1; rateWrData = 8'h41; statusAccess = 1;
    @(negedge clk); clearIn();
    chk("R7 exit wins over set", clkGateReq, 0);
  endtask

  task automatic testSelfReset();
    writeRate(8'b11_0_100_11);
    chk("R5 pulse high", swRstPulse, 1);
    chk("R6 clkgate up with reset", clkGateReq, 1);
    chk("R8 shadow bits 7 6", shadowVal, 8'hD3);
    @(negedge clk);
    chk("R5 pulse cleared", swRstPulse, 0);
    chk("R7 internal reset exits", clkGateReq, 0);
    chk("R5 rate kept", rateCode, 3);
    chk("R5 precomp kept", precompCode, 4);
    writeCfg(2'b00);
    chk("R8 shadow ignores cfg", shadowVal, 8'hD3);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testReset();
    testRateWrite();
    testLastWriter();
    testExits();
    testSelfReset();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule